// File: doc/BRIEF.md
# Pipelined Synchronous Burst Memory

This block models a single-port synchronous memory with a registered front end and a registered read output. On each rising clock edge it samples the address, three chip enables, two address strobes (one meant for a processor, one for a memory controller), a burst-advance input, the write controls and the write data. A selected strobe starts an access. Burst-advance cycles then step a two-bit counter through a four-word block, in either linear or interleaved order. A read returns its word one clock after the access is registered. A four-word burst therefore delivers its first word after the pipeline delay and the rest at one word per clock.

Writes may cover any subset of the byte lanes. Each lane holds eight data bits and one parity bit. A global-write input overrides the per-lane selects. A word written in one cycle is returned by a read of the same word issued in the very next cycle. When a deselect is registered, the output keeps driving for one extra cycle and then releases the bus. A combinational output-enable input gates the drive. The bus is split into an input, an output and a drive flag, so the pad logic outside this block can build the shared tristate pins.

Top module: `syncBurstSram`

## Requirements
- R1: After reset the data bus is not driven: `dataOutEn` is 0 and `dataOut` is 0.
- R2: When `adspN` or `adscN` is low at an edge and the chip is selected (`ce1N`=0, `ce2`=1, `ce3N`=0), the address is captured. For a read, the word appears on `dataOut` with `dataOutEn`=1 after the following edge.
- R3: A strobe at an edge where any chip enable is inactive registers a deselect and loads no address. Later burst-advance or write-control cycles make no access and write nothing until a new selected strobe arrives.
- R4: An access started by `adspN` low is a read, even when the write controls are asserted. The array keeps its contents.
- R5: With `gwN` low, all four lanes are written, whatever `bweN` and `bwN` hold.
- R6: With `gwN` high and `bweN` low, lane i is written when `bwN[i]` is low. Lane i is bits [9i+8:9i] of the data bus, and bit 9i+8 is that lane's parity bit. With `gwN` and `bweN` both high, nothing is written.
- R7: With `burstLinear`=1, advance cycles produce the low two address bits (start+n) mod 4, one word per clock. The upper address bits stay fixed.
- R8: With `burstLinear`=0, advance cycles produce the low two address bits start XOR n.
- R9: An advance cycle with write controls asserted writes `dataIn` to the next burst address.
- R10: A read registered in the cycle right after a write to the same address returns the newly written word.
- R11: After a read, a registered deselect keeps the bus driven with the last read word for one more cycle. On the cycle after that, `dataOutEn` is 0.
- R12: `oeN` high forces `dataOutEn` to 0 at once, with no clock edge needed. `oeN` low restores the drive.
- R13: In an active access with no strobe, no advance and no write controls, the same address is re-read and the output holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| ce1N | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3N | input | 1 | Chip enable, active low |
| adspN | input | 1 | Processor-side address strobe, active low, read only |
| adscN | input | 1 | Controller-side address strobe, active low |
| advN | input | 1 | Burst advance, active low |
| gwN | input | 1 | Global write, active low |
| bweN | input | 1 | Byte-write enable, active low |
| bwN | input | LANES | Per-lane write selects, active low |
| burstLinear | input | 1 | 1 selects linear burst order, 0 selects interleaved |
| oeN | input | 1 | Asynchronous output enable, active low |
| dataIn | input | LANES*LANE_W | Write data from the pads |
| dataOut | output | LANES*LANE_W | Read data to the pads, 0 when not driven |
| dataOutEn | output | 1 | Pad drive enable |

## Verification
The hardest situation to reach from the ports is a deselect that arrives while the output stage still holds live read data. The stimulus must place the deselect strobe exactly one cycle after a read strobe, so that the read reaches the output register on the same edge that registers the deselect. The bench does this and then samples on two consecutive cycles, which shows the extra cycle of drive and then the release. A second hard case is a burst-advance cycle with global write asserted after a deselect. Here the stimulus holds advance and write low for several cycles and then reads back the addresses a stale burst would have touched.

// File: rtl/sbsPkg.sv
package sbsPkg;
  // One-hot operation strobes from the control pipeline stage to the datapath.
  typedef struct packed {
    logic rd;
    logic wr;
    logic desel;
  } strobes_t;
endpackage

// File: rtl/sbsCtrl.sv
module sbsCtrl
  import sbsPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              adspN,
  input  logic              adscN,
  input  logic              advN,
  input  logic              gwN,
  input  logic              bweN,
  input  logic [LANES-1:0]  bwN,
  input  logic              burstLinear,
  output strobes_t          strobes,
  output logic [ADDR_W-1:0] addrQ,
  output logic [LANES-1:0]  maskQ
);
  localparam int HI = ADDR_W - 1;

  logic              chipSel;
  logic              anyStrobe;
  logic [LANES-1:0]  wrMask;
  logic              sessionQ;
  logic [ADDR_W-1:0] baseQ;
  logic [1:0]        cntQ;
  logic [1:0]        cntNext;
  logic [1:0]        lowNext;

  assign chipSel   = !ce1N && ce2 && !ce3N;
  assign anyStrobe = !adspN || !adscN;

  always_comb begin
    if (!gwN)       wrMask = '1;
    else if (!bweN) wrMask = ~bwN;
    else            wrMask = '0;
  end

  assign cntNext = cntQ + 2'd1;
  assign lowNext = burstLinear ? (baseQ[1:0] + cntNext) : (baseQ[1:0] ^ cntNext);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sessionQ <= 1'b0;
      baseQ    <= '0;
      cntQ     <= 2'd0;
      addrQ    <= '0;
      maskQ    <= '0;
      strobes  <= '0;
    end else begin
      strobes <= '0;
      maskQ   <= '0;
      if (anyStrobe) begin
        if (chipSel) begin
          sessionQ <= 1'b1;
          baseQ    <= addr;
          cntQ     <= 2'd0;
          addrQ    <= addr;
          if (!adspN || wrMask == '0) begin
            strobes.rd <= 1'b1;
          end else begin
            strobes.wr <= 1'b1;
            maskQ      <= wrMask;
          end
        end else begin
          sessionQ      <= 1'b0;
          strobes.desel <= 1'b1;
        end
      end else if (sessionQ) begin
        if (!advN) begin
          cntQ  <= cntNext;
          addrQ <= {baseQ[HI:2], lowNext};
        end
        if (wrMask == '0) begin
          strobes.rd <= 1'b1;
        end else begin
          strobes.wr <= 1'b1;
          maskQ      <= wrMask;
        end
      end
    end
  end

  // R4: a selected processor strobe always becomes a read
  assert_proc_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!adspN && !ce1N && ce2 && !ce3N) |=> (strobes.rd && !strobes.wr));

  // R5: global write covers every lane
  assert_global_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    (adspN && !adscN && !gwN && !ce1N && ce2 && !ce3N) |=> (strobes.wr && (&maskQ)));

  // R3: a strobe with an inactive chip enable registers a deselect
  assert_deselect_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((!adspN || !adscN) && (ce1N || !ce2 || ce3N)) |=> (strobes.desel && !strobes.rd && !strobes.wr));

  // R13: with no strobe and no advance the address holds
  assert_suspend_hold_R13: assert property (@(posedge clk) disable iff (!rstN)
    (adspN && adscN && advN) |=> $stable(addrQ));
endmodule

// File: rtl/sbsDatapath.sv
module sbsDatapath
  import sbsPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobes_t                strobes,
  input  logic [ADDR_W-1:0]       addrQ,
  input  logic [LANES-1:0]        maskQ,
  input  logic [LANES*LANE_W-1:0] dataIn,
  input  logic                    oeN,
  output logic [LANES*LANE_W-1:0] dataOut,
  output logic                    dataOutEn
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] dinQ;
  logic [DATA_W-1:0] outQ;
  logic              outLive;
  logic              deselPend;

  always_ff @(posedge clk) begin
    dinQ <= dataIn;
  end

  always_ff @(posedge clk) begin
    if (strobes.wr) begin
      for (int lane = 0; lane < LANES; lane++) begin
        if (maskQ[lane]) mem[addrQ][lane*LANE_W +: LANE_W] <= dinQ[lane*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outQ      <= '0;
      outLive   <= 1'b0;
      deselPend <= 1'b0;
    end else if (strobes.rd) begin
      outQ      <= mem[addrQ];
      outLive   <= 1'b1;
      deselPend <= 1'b0;
    end else if (strobes.wr) begin
      outLive   <= 1'b0;
      deselPend <= 1'b0;
    end else if (strobes.desel) begin
      if (deselPend) outLive <= 1'b0;
      deselPend <= 1'b1;
    end else if (deselPend) begin
      outLive   <= 1'b0;
      deselPend <= 1'b0;
    end
  end

  assign dataOutEn = !oeN && outLive;
  assign dataOut   = dataOutEn ? outQ : '0;

  // R11: the first registered deselect keeps live data driven one more cycle
  assert_desel_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.desel && !deselPend && outLive) |=> (outLive && $stable(outQ)));

  // R11: once the extra cycle is spent, the output releases unless a read refills it
  assert_desel_release_R11: assert property (@(posedge clk) disable iff (!rstN)
    (deselPend && !strobes.rd) |=> !outLive);

  // R9: a write cycle turns the output stage off
  assert_write_turnaround_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wr |=> !outLive);
endmodule

// File: rtl/syncBurstSram.sv
module syncBurstSram
  import sbsPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    ce1N,
  input  logic                    ce2,
  input  logic                    ce3N,
  input  logic                    adspN,
  input  logic                    adscN,
  input  logic                    advN,
  input  logic                    gwN,
  input  logic                    bweN,
  input  logic [LANES-1:0]        bwN,
  input  logic                    burstLinear,
  input  logic                    oeN,
  input  logic [LANES*LANE_W-1:0] dataIn,
  output logic [LANES*LANE_W-1:0] dataOut,
  output logic                    dataOutEn
);
  strobes_t          strobes;
  logic [ADDR_W-1:0] addrQ;
  logic [LANES-1:0]  maskQ;

  sbsCtrl #(.ADDR_W(ADDR_W), .LANES(LANES)) uCtrl (
    .clk(clk), .rstN(rstN), .addr(addr), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .adspN(adspN), .adscN(adscN), .advN(advN), .gwN(gwN), .bweN(bweN), .bwN(bwN),
    .burstLinear(burstLinear), .strobes(strobes), .addrQ(addrQ), .maskQ(maskQ)
  );

  sbsDatapath #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .addrQ(addrQ), .maskQ(maskQ),
    .dataIn(dataIn), .oeN(oeN), .dataOut(dataOut), .dataOutEn(dataOutEn)
  );
endmodule

// File: tb/tb_syncBurstSram.sv
module tb_syncBurstSram;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 36;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic ce1N = 1'b0, ce2 = 1'b1, ce3N = 1'b0;
  logic adspN = 1'b1, adscN = 1'b1, advN = 1'b1;
  logic gwN = 1'b1, bweN = 1'b1;
  logic [3:0] bwN = 4'hF;
  logic burstLinear = 1'b1;
  logic oeN = 1'b0;
  logic [DW-1:0] dataIn = '0;
  logic [DW-1:0] dataOut;
  logic dataOutEn;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  logic [DW-1:0] model [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  syncBurstSram dut (
    .clk(clk), .rstN(rstN), .addr(addr), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .adspN(adspN), .adscN(adscN), .advN(advN), .gwN(gwN), .bweN(bweN), .bwN(bwN),
    .burstLinear(burstLinear), .oeN(oeN), .dataIn(dataIn),
    .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

  task automatic checkVal(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    adspN = 1'b1; adscN = 1'b1; advN = 1'b1; gwN = 1'b1; bweN = 1'b1; bwN = 4'hF;
    ce1N = 1'b0; ce2 = 1'b1; ce3N = 1'b0;
  endtask

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw, logic [3:0] m);
    logic [DW-1:0] r = old;
    for (int i = 0; i < 4; i++) if (m[i]) r[i*9 +: 9] = nw[i*9 +: 9];
    return r;
  endfunction

  function automatic logic [3:0] laneMask(logic g, logic be, logic [3:0] b);
    if (!g) return 4'hF;
    if (!be) return ~b;
    return 4'h0;
  endfunction

  task automatic writeWord(logic [AW-1:0] a, logic [DW-1:0] d, logic g, logic be, logic [3:0] b);
    adscN = 1'b0; addr = a; dataIn = d; gwN = g; bweN = be; bwN = b;
    tick();
    idle();
    tick();
    model[a] = merge(model[a], d, laneMask(g, be, b));
  endtask

  task automatic readWord(logic [AW-1:0] a, string req);
    adspN = 1'b0; addr = a;
    tick();
    idle();
    tick();
    checkVal({req, " drive"}, {35'd0, dataOutEn}, 36'd1);
    checkVal(req, dataOut, model[a]);
  endtask

  task automatic testReset();
    checkVal("R1 drive", {35'd0, dataOutEn}, 36'd0);
    checkVal("R1 data", dataOut, 36'd0);
  endtask

  task automatic testWrites();
    writeWord(8'h10, 36'h9_1234_5678, 1'b0, 1'b1, 4'hF);
    readWord(8'h10, "R5 gw over bwe high");
    writeWord(8'h11, 36'hA_BCDE_F012, 1'b0, 1'b0, 4'b0101);
    readWord(8'h11, "R5 gw over bw");
    writeWord(8'h10, 36'hF_0F0F_0F0F, 1'b1, 1'b0, 4'b1010);
    readWord(8'h10, "R2 R6 lanes 0 2");
    writeWord(8'h10, 36'h8_00FF_FF00, 1'b1, 1'b0, 4'b0111);
    readWord(8'h10, "R6 lane 3 parity");
    writeWord(8'h11, 36'h0_0000_0000, 1'b1, 1'b1, 4'h0);
    readWord(8'h11, "R6 no enable");
  endtask

  task automatic testProcRead();
    adspN = 1'b0; addr = 8'h10; gwN = 1'b0; dataIn = 36'h1_1111_1111;
    tick();
    idle();
    tick();
    checkVal("R4 proc strobe reads", dataOut, model[8'h10]);
    readWord(8'h10, "R4 array unchanged");
  endtask

  task automatic burstRead(logic [AW-1:0] start, logic lin, string req);
    burstLinear = lin;
    adspN = 1'b0; addr = start;
    tick();
    adspN = 1'b1; advN = 1'b0;
    for (int n = 0; n < 4; n++) begin
      logic [1:0] lo;
      lo = lin ? (start[1:0] + 2'(n)) : (start[1:0] ^ 2'(n));
      tick();
      checkVal(req, dataOut, model[{start[AW-1:2], lo}]);
    end
    idle();
    burstLinear = 1'b1;
  endtask

  task automatic testBursts();
    for (int i = 0; i < 4; i++) writeWord(8'h20 + 8'(i), 36'h3_0000_0000 + 36'(i * 36'h111), 1'b0, 1'b1, 4'hF);
    burstRead(8'h22, 1'b1, "R7 linear order");
    burstRead(8'h21, 1'b0, "R8 interleaved order");
  endtask

  task automatic testBurstWrite();
    adscN = 1'b0; addr = 8'h32; gwN = 1'b0; dataIn = 36'h4_AAAA_0000;
    tick();
    adscN = 1'b1; advN = 1'b0;
    for (int n = 1; n < 4; n++) begin
      dataIn = 36'h4_AAAA_0000 + 36'(n);
      tick();
    end
    idle();
    tick();
    for (int n = 0; n < 4; n++) model[{6'b001100, 2'(2 + n)}] = 36'h4_AAAA_0000 + 36'(n);
    for (int n = 0; n < 4; n++) readWord({6'b001100, 2'(n)}, "R9 burst write");
  endtask

  task automatic testPassThrough();
    adscN = 1'b0; addr = 8'h40; gwN = 1'b0; dataIn = 36'h5_5A5A_A5A5;
    tick();
    idle();
    adspN = 1'b0; addr = 8'h40;
    tick();
    idle();
    tick();
    checkVal("R10 pass through", dataOut, 36'h5_5A5A_A5A5);
    model[8'h40] = 36'h5_5A5A_A5A5;
  endtask

  task automatic testDeselect();
    adspN = 1'b0; addr = 8'h20;
    tick();
    ce1N = 1'b1;
    tick();
    idle();
    checkVal("R11 read live", {35'd0, dataOutEn}, 36'd1);
    checkVal("R11 read data", dataOut, model[8'h20]);
    tick();
    checkVal("R11 extra cycle drive", {35'd0, dataOutEn}, 36'd1);
    checkVal("R11 extra cycle data", dataOut, model[8'h20]);
    tick();
    checkVal("R11 released", {35'd0, dataOutEn}, 36'd0);
    advN = 1'b0; gwN = 1'b0; dataIn = 36'hE_EEEE_EEEE;
    for (int n = 0; n < 3; n++) begin
      tick();
      checkVal("R3 stale advance no drive", {35'd0, dataOutEn}, 36'd0);
    end
    idle();
    tick();
    readWord(8'h21, "R3 no stale write 21");
    readWord(8'h22, "R3 no stale write 22");
  endtask

  task automatic testOeAndSuspend();
    readWord(8'h23, "R2 plain read");
    oeN = 1'b1;
    #1;
    checkVal("R12 oe off", {35'd0, dataOutEn}, 36'd0);
    oeN = 1'b0;
    #1;
    checkVal("R12 oe on", {35'd0, dataOutEn}, 36'd1);
    for (int n = 0; n < 3; n++) begin
      tick();
      checkVal("R13 suspend holds", dataOut, model[8'h23]);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    for (int i = 0; i < 256; i++) writeWord(8'(i), 36'h0, 1'b0, 1'b1, 4'hF);
    testWrites();
    testProcRead();
    testBursts();
    testBurstWrite();
    testPassThrough();
    testDeselect();
    testOeAndSuspend();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule